// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Time

This block serialises parallel characters onto a single asynchronous line. Each character is framed by a low start bit, followed by one to eight data bits sent least significant bit first, an optional parity bit, and a high stop period. The stop period can be set in sixteenth-of-a-bit steps, from one sixteenth of a bit up to two whole bits. The block also has a break control that holds the line low.

Timing is driven by an oversampling tick enable that comes from an external rate generator. A clock-factor setting gives the number of ticks that make up one bit time. Characters enter through a valid/ready handshake. When the next character is already waiting as the stop period finishes, its start bit follows at once, so characters can run back to back. The configuration inputs may only change while the line is idle.

Top module: `async_tx_frac`

## Requirements
- R1: After reset the line is high and, when break is not requested, the handshake is ready.
- R2: A frame is a low start bit and then cfgLen+1 data bits, least significant bit first (cfgLen code n means n+1 bits). Each bit lasts one bit time.
- R3: cfgParity codes are 1 odd, 2 even, 3 mark (always 1) and 4 space (always 0). Any other code means no parity bit. The parity bit follows the last data bit. Odd parity makes the count of ones across the data bits and the parity bit odd; even parity makes it even.
- R4: cfgFactor codes 0, 1, 2 and 3 give 1, 16, 32 and 64 ticks per bit time. The line state advances only on cycles where tickEn is high.
- R5: With a factor of 16, the stop period lasts exactly cfgStop+1 ticks (1 to 32 sixteenths of a bit).
- R6: With any other factor, the stop period is rounded up to whole bits: one bit time when cfgStop is below 16, and two bit times otherwise.
- R7: inReady is high only in two cases: when the transmitter is idle, or on the tick cycle that ends the stop period. In both cases break must be released. A character is taken on a cycle where inValid and inReady are both high.
- R8: A character taken at the end of a stop period begins its start bit on the next cycle, with no idle time in between.
- R9: While cfgBreak is high, an idle line is held low and no character is accepted. A character already in progress finishes its frame first.
- R10: Changes to inData after a character has been taken do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Oversampling tick enable |
| inValid | input | 1 | Character offered |
| inData | input | 8 | Character bits, bit 0 sent first |
| inReady | output | 1 | Character accepted when high together with inValid |
| cfgLen | input | 3 | Data bits minus one |
| cfgParity | input | 3 | Parity mode code |
| cfgStop | input | 5 | Stop time in sixteenths minus one |
| cfgFactor | input | 2 | Ticks-per-bit code |
| cfgBreak | input | 1 | Hold the line low when idle |
| txLine | output | 1 | Serial output, idles high |

## Verification
Some properties are checked by assertions on every cycle. The tick counter holds its value on cycles without a tick. A reloaded stop count is never zero. Phases follow the order start, data, parity, stop. A stop phase exits only to idle or to a new start. An accepted character always enters the start phase.

Other behaviour can only be shown by the bench's scenarios against its queue-based line model. These include the exact bit values on the line, the parity polarity, the rounded and fractional stop lengths, back-to-back spacing, break hold, and immunity to late data changes.

// File: rtl/async_tx_frac_pkg.sv
package async_tx_frac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } txState_e;

  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef struct packed {
    logic loadChar;
    logic loadBit;
    logic loadStop;
    logic shift;
  } txStrobe_t;

endpackage

// File: rtl/async_tx_frac_datapath.sv
module async_tx_frac_datapath
  import async_tx_frac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  txStrobe_t                 strobes,
  input  logic [DATA_W-1:0]         inData,
  input  logic [$clog2(DATA_W)-1:0] cfgLen,
  input  logic [2:0]                cfgParity,
  input  logic [STOP_W-1:0]         cfgStop,
  input  logic [1:0]                cfgFactor,
  output logic                      dataBit,
  output logic                      parityBit,
  output logic                      cntLast,
  output logic                      bitsLast
);
  localparam int BW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] masked;
  logic              parReg;
  logic              parNext;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  bitTicks;
  logic [CNT_W-1:0]  stopTicks;
  logic [BW-1:0]     bitsLeft;

  // Keep only the data bits that will actually be sent.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = inData[i] & (i <= int'(cfgLen));
    end
  end

  always_comb begin
    case (cfgParity)
      PAR_ODD:   parNext = ~(^masked);
      PAR_EVEN:  parNext = ^masked;
      PAR_MARK:  parNext = 1'b1;
      default:   parNext = 1'b0;
    endcase
  end

  always_comb begin
    case (cfgFactor)
      2'd0:    bitTicks = CNT_W'(1);
      2'd1:    bitTicks = CNT_W'(16);
      2'd2:    bitTicks = CNT_W'(32);
      default: bitTicks = CNT_W'(64);
    endcase
  end

  // Fractional stop only at factor 16; otherwise round up to whole bits.
  always_comb begin
    if (cfgFactor == 2'd1) stopTicks = CNT_W'(cfgStop) + CNT_W'(1);
    else if (cfgStop[STOP_W-1]) stopTicks = bitTicks << 1;
    else stopTicks = bitTicks;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parReg   <= 1'b0;
      bitsLeft <= '0;
    end else if (strobes.loadChar) begin
      shiftReg <= inData;
      parReg   <= parNext;
      bitsLeft <= BW'(cfgLen) + BW'(1);
    end else if (strobes.shift) begin
      shiftReg <= shiftReg >> 1;
      bitsLeft <= bitsLeft - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= CNT_W'(1);
    else if (strobes.loadBit) cnt <= bitTicks;
    else if (strobes.loadStop) cnt <= stopTicks;
    else if (tickEn) cnt <= cnt - CNT_W'(1);
  end

  assign dataBit   = shiftReg[0];
  assign parityBit = parReg;
  assign cntLast   = (cnt == CNT_W'(1));
  assign bitsLast  = (bitsLeft == BW'(1));

  // R4: without a tick or reload the phase counter does not move
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobes.loadBit && !strobes.loadStop) |=> $stable(cnt));

  // R5: a freshly loaded stop period always has at least one tick
  a_r5_stop_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStop |=> (cnt != '0));

endmodule

// File: rtl/async_tx_frac_ctrl.sv
module async_tx_frac_ctrl
  import async_tx_frac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       inValid,
  input  logic       cfgBreak,
  input  logic [2:0] cfgParity,
  input  logic       cntLast,
  input  logic       bitsLast,
  input  logic       dataBit,
  input  logic       parityBit,
  output logic       inReady,
  output logic       txLine,
  output txStrobe_t  strobes
);
  txState_e state, stateNext;
  logic phaseEnd;
  logic accept;
  logic hasParity;

  assign phaseEnd  = tickEn && cntLast;
  assign hasParity = (cfgParity >= PAR_ODD) && (cfgParity <= PAR_SPACE);
  assign inReady   = !cfgBreak &&
                     ((state == ST_IDLE) || ((state == ST_STOP) && phaseEnd));
  assign accept    = inValid && inReady;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strobes.loadChar = 1'b1;
          strobes.loadBit  = 1'b1;
          stateNext        = ST_START;
        end
      end
      ST_START: begin
        if (phaseEnd) begin
          strobes.loadBit = 1'b1;
          stateNext       = ST_DATA;
        end
      end
      ST_DATA: begin
        if (phaseEnd) begin
          strobes.shift = 1'b1;
          if (!bitsLast) begin
            strobes.loadBit = 1'b1;
          end else if (hasParity) begin
            strobes.loadBit = 1'b1;
            stateNext       = ST_PARITY;
          end else begin
            strobes.loadStop = 1'b1;
            stateNext        = ST_STOP;
          end
        end
      end
      ST_PARITY: begin
        if (phaseEnd) begin
          strobes.loadStop = 1'b1;
          stateNext        = ST_STOP;
        end
      end
      ST_STOP: begin
        if (accept) begin
          strobes.loadChar = 1'b1;
          strobes.loadBit  = 1'b1;
          stateNext        = ST_START;
        end else if (phaseEnd) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    case (state)
      ST_START:  txLine = 1'b0;
      ST_DATA:   txLine = dataBit;
      ST_PARITY: txLine = parityBit;
      ST_STOP:   txLine = 1'b1;
      default:   txLine = !cfgBreak;
    endcase
  end

  // R8: an accepted character always enters its start bit next
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (state == ST_START));

  // R2: the data phase is entered only from the start bit
  a_r2_data_after_start: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DATA) && ($past(state) != ST_DATA)) |-> ($past(state) == ST_START));

  // R3: the parity bit only follows the data bits
  a_r3_parity_after_data: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PARITY) && ($past(state) != ST_PARITY)) |-> ($past(state) == ST_DATA));

  // R7: a stop period ends in idle or directly in a new start bit
  a_r7_stop_exit: assert property (@(posedge clk) disable iff (!rstN)
    (($past(state) == ST_STOP) && (state != ST_STOP)) |-> ((state == ST_IDLE) || (state == ST_START)));

endmodule

// File: rtl/async_tx_frac.sv
module async_tx_frac
  import async_tx_frac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  input  logic [2:0] cfgLen,
  input  logic [2:0] cfgParity,
  input  logic [4:0] cfgStop,
  input  logic [1:0] cfgFactor,
  input  logic       cfgBreak,
  output logic       txLine
);
  txStrobe_t strobes;
  logic dataBit, parityBit, cntLast, bitsLast;

  async_tx_frac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inValid(inValid),
    .cfgBreak(cfgBreak), .cfgParity(cfgParity), .cntLast(cntLast),
    .bitsLast(bitsLast), .dataBit(dataBit), .parityBit(parityBit),
    .inReady(inReady), .txLine(txLine), .strobes(strobes)
  );

  async_tx_frac_datapath #(.DATA_W(8), .STOP_W(5), .CNT_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes),
    .inData(inData), .cfgLen(cfgLen), .cfgParity(cfgParity),
    .cfgStop(cfgStop), .cfgFactor(cfgFactor), .dataBit(dataBit),
    .parityBit(parityBit), .cntLast(cntLast), .bitsLast(bitsLast)
  );

endmodule

// File: tb/sim_async_tx_frac.sv
`timescale 1ns/1ps
module sim_async_tx_frac;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady;
  logic [2:0] cfgLen = 3'd7;
  logic [2:0] cfgParity = 3'd0;
  logic [4:0] cfgStop = 5'd15;
  logic [1:0] cfgFactor = 2'd1;
  logic cfgBreak = 1'b0;
  logic txLine;

  int tests = 0;
  int fails = 0;
  int tickGap = 1;
  int tickCnt = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference model: queue of line levels with remaining tick counts
  bit lvlQ[$];
  int durQ[$];

  always #2.5 clk = ~clk;

  async_tx_frac u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inValid(inValid),
    .inData(inData), .inReady(inReady), .cfgLen(cfgLen),
    .cfgParity(cfgParity), .cfgStop(cfgStop), .cfgFactor(cfgFactor),
    .cfgBreak(cfgBreak), .txLine(txLine)
  );

  function automatic int ticksPerBit();
    case (cfgFactor)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int stopLen();
    if (cfgFactor == 2'd1) return int'(cfgStop) + 1;
    return ((int'(cfgStop) + 16) / 16) * ticksPerBit();
  endfunction

  function automatic bit modelReady();
    if (cfgBreak) return 0;
    if (lvlQ.size() == 0) return 1;
    return (lvlQ.size() == 1) && (durQ[0] == 1) && tickEn;
  endfunction

  function automatic bit modelLine();
    if (lvlQ.size() == 0) return !cfgBreak;
    return lvlQ[0];
  endfunction

  task automatic pushFrame(input logic [7:0] d);
    int f = ticksPerBit();
    int ones = 0;
    lvlQ.push_back(1'b0); durQ.push_back(f);
    for (int i = 0; i <= int'(cfgLen); i++) begin
      lvlQ.push_back(d[i]); durQ.push_back(f);
      ones += d[i];
    end
    case (cfgParity)
      3'd1: begin lvlQ.push_back((ones % 2) == 0); durQ.push_back(f); end
      3'd2: begin lvlQ.push_back((ones % 2) == 1); durQ.push_back(f); end
      3'd3: begin lvlQ.push_back(1'b1); durQ.push_back(f); end
      3'd4: begin lvlQ.push_back(1'b0); durQ.push_back(f); end
      default: ;
    endcase
    lvlQ.push_back(1'b1); durQ.push_back(stopLen());
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      lvlQ.delete(); durQ.delete();
    end else begin
      bit acc;
      acc = inValid && modelReady();
      if (tickEn && lvlQ.size() > 0) begin
        durQ[0] = durQ[0] - 1;
        if (durQ[0] == 0) begin
          void'(lvlQ.pop_front()); void'(durQ.pop_front());
        end
      end
      if (acc) pushFrame(inData);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      tests++;
      if (txLine !== modelLine() || inReady !== modelReady()) begin
        fails++;
        $display("FAIL %s line=%b ready=%b expected line=%b ready=%b at %0t",
                 curReq, txLine, inReady, modelLine(), modelReady(), $time);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      tickCnt++;
      tickEn = ((tickCnt % tickGap) == 0);
    end
  end

  task automatic check(input string req, input bit cond, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendChar(input logic [7:0] d);
    bit acc;
    @(posedge clk); #1;
    inValid = 1'b1; inData = d;
    forever begin
      @(negedge clk); acc = inReady;
      @(posedge clk);
      if (acc) break;
    end
    #1 inValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (lvlQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic measureStopRun(output int run);
    run = 0;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    while (txLine !== 1'b1) @(negedge clk);
    while (txLine === 1'b1) begin run++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int run;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 line after reset", txLine === 1'b1, int'(txLine), 1);
    check("R1 ready after reset", inReady === 1'b1, int'(inReady), 1);

    // R2/R8: factor 16, 8 bits, no parity, 1 bit stop, back to back
    curReq = "R2";
    sendChar(8'hA5);
    curReq = "R8";
    sendChar(8'h3C);
    waitIdle();

    // R5: fractional stop, measured directly on the line
    curReq = "R5";
    cfgStop = 5'd4;
    fork
      begin sendChar(8'h00); sendChar(8'h00); end
      measureStopRun(run);
    join
    check("R5 stop run 5 ticks", run == 5, run, 5);
    waitIdle();
    cfgStop = 5'd0;
    sendChar(8'h00); sendChar(8'h81);
    waitIdle();

    // R3/R4: each parity mode, factor 1, sparse ticks, varied lengths
    tickGap = 3;
    cfgFactor = 2'd0;
    for (int p = 0; p < 6; p++) begin
      curReq = (p == 0) ? "R4" : "R3";
      cfgParity = 3'(p);
      cfgLen = 3'(7 - p);
      sendChar(8'h5B); sendChar(8'hE6);
      waitIdle();
    end
    cfgLen = 3'd0;
    cfgParity = 3'd1;
    sendChar(8'h01); sendChar(8'h00);
    waitIdle();

    // R6: rounded stop at other factors
    curReq = "R6";
    cfgLen = 3'd4; cfgParity = 3'd2;
    cfgFactor = 2'd2; cfgStop = 5'd20; tickGap = 1;
    sendChar(8'h17); sendChar(8'h08);
    waitIdle();
    cfgFactor = 2'd3; cfgStop = 5'd3; tickGap = 2;
    sendChar(8'h1F); sendChar(8'h02);
    waitIdle();
    cfgFactor = 2'd0; cfgStop = 5'd31;
    sendChar(8'h0A); sendChar(8'h15);
    waitIdle();

    // R10: data changes after acceptance are ignored
    curReq = "R10";
    cfgFactor = 2'd1; cfgStop = 5'd7; tickGap = 1; cfgLen = 3'd7; cfgParity = 3'd1;
    sendChar(8'hC3);
    inData = 8'h3C;
    repeat (40) @(posedge clk);
    #1 inData = 8'hFF;
    waitIdle();

    // R9: break requested mid-frame, frame completes, then line held low
    curReq = "R9";
    fork
      sendChar(8'h96);
      begin repeat (30) @(posedge clk); #1 cfgBreak = 1'b1; end
    join
    waitIdle();
    check("R9 line low in break", txLine === 1'b0, int'(txLine), 0);
    check("R9 not ready in break", inReady === 1'b0, int'(inReady), 0);
    fork
      sendChar(8'h55);
      begin
        repeat (25) @(negedge clk);
        check("R9 no accept in break", txLine === 1'b0 && inReady === 1'b0,
              int'(txLine), 0);
        @(posedge clk); #1 cfgBreak = 1'b0;
      end
    join
    waitIdle();
    curReq = "R7";
    check("R7 ready when idle", inReady === 1'b1, int'(inReady), 1);
    check("R1 line idle high", txLine === 1'b1, int'(txLine), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule